// File: doc/BRIEF.md
# Reconfigurable Watermark FIFO

This block is a 32-bit FIFO built on a 256-entry dual-port memory. Its depth and two threshold levels are not fixed at build time. Software writes a staged configuration word and then triggers an apply step through a control register. The apply step copies the staged word into the active settings and clears the FIFO.

While the apply step runs, the apply bit reads back as 1, and both data ports refuse traffic. After a fixed number of cycles the bit clears on its own, and the FIFO runs with the new depth and thresholds. Software is expected to poll the apply bit and to see 0 before it sets the bit again.

The data side is first-word-fall-through. Full and empty follow the active depth. One threshold flag tells a reader that enough data is waiting. The other tells a writer that enough room is free. A push into a full FIFO or a pop from an empty one leaves the FIFO unchanged and raises an error pulse.

Top module: `wmfifo_top`

## Requirements
- R1: The configuration register (`reg_sel`=0) stores written bits 29:0 and reads back bits 31:30 as zero. A write to it leaves the active depth, the thresholds, the flags and the data untouched until the next apply.
- R2: Each field of the configuration register is 10 bits wide, with its value in the upper 8 bits; the lowest 2 bits of a field are stored but not used.
  - The depth field occupies bits 29:20, the read threshold bits 19:10 and the write threshold bits 9:0.
  - A depth value of 0 means 256 entries.
- R3: Writing the control register (`reg_sel`=1) with bit 0 set while `busy` is 0 loads the staged configuration into the active settings. After that write edge, `busy` and control bit 0 read 1 for exactly 4 cycles and then read 0.
- R4: While `busy` is high, and in the cycle of the apply write itself, pushes and pops are discarded without an error pulse. When `busy` falls, the FIFO is empty.
- R5: Control bits 3:1 are stored on every control write, whatever the value of bit 0. They read back in place and drive `opt_en[2:0]`. Control bits 31:4 read as zero.
- R6: Data leaves in the order it was pushed. `pop_data` shows the oldest entry whenever the FIFO is not empty.
- R7: `full` is high exactly when occupancy equals the active depth, and `empty` is high exactly when occupancy is zero.
- R8: `rd_wm_hit` is high exactly when occupancy is at least the active read threshold.
- R9: `wr_wm_hit` is high exactly when (active depth − occupancy) is at least the active write threshold.
- R10: A push while full, or a pop while empty, leaves the FIFO unchanged. One cycle after the attempt, `err` pulses high for one cycle. A pop paired with a push when full still removes an entry and drops the push.
- R11: A control write with bit 0 set while `busy` is high neither restarts nor lengthens the apply step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 configuration, 1 control |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for the selected register |
| push | input | 1 | Push request |
| push_data | input | 32 | Data to push |
| pop | input | 1 | Pop request |
| pop_data | output | 32 | Oldest entry (valid when not empty) |
| full | output | 1 | Occupancy equals active depth |
| empty | output | 1 | Occupancy is zero |
| rd_wm_hit | output | 1 | Occupancy at or above read threshold |
| wr_wm_hit | output | 1 | Free space at or above write threshold |
| err | output | 1 | One-cycle pulse after a refused push or pop |
| busy | output | 1 | Apply step in progress |
| opt_en | output | 3 | Control register bits 3:1 |

## Verification
If the pointers are not cleared on an apply, or the depth is decoded wrongly, `empty`, `full` and the two threshold flags go wrong in the first cycle after `busy` falls. `pop_data` goes wrong within one push. If an apply loads early, or the busy counter is wrong, the threshold flags or the control register readback differ in the very next cycle. Occupancy errors at the wrap boundary show up as a missing or extra `err` pulse one cycle after the refused operation.

// File: rtl/wmfifo_pkg.sv
package wmfifo_pkg;

    localparam int DATA_W     = 32;
    localparam int CFG_W      = 32;
    localparam int ADDR_W     = 8;
    localparam int FIELD_W    = 10;
    localparam int FRAC_W     = FIELD_W - ADDR_W;
    localparam int WR_LSB     = 0;
    localparam int RD_LSB     = FIELD_W;
    localparam int SZ_LSB     = 2 * FIELD_W;
    localparam int EN_W       = 3;
    localparam int RECONF_CYC = 4;
    localparam logic [CFG_W-1:0] CFG_MASK = CFG_W'((64'd1 << (3 * FIELD_W)) - 64'd1);

    typedef struct packed {
        logic [ADDR_W-1:0] size;
        logic [ADDR_W-1:0] rd_wm;
        logic [ADDR_W-1:0] wr_wm;
    } fifo_cfg_t;

    typedef enum logic {
        SEL_CFG  = 1'b0,
        SEL_CTRL = 1'b1
    } reg_sel_e;

    function automatic fifo_cfg_t decode_cfg(input logic [CFG_W-1:0] w);
        fifo_cfg_t c;
        c.size  = w[SZ_LSB + FRAC_W +: ADDR_W];
        c.rd_wm = w[RD_LSB + FRAC_W +: ADDR_W];
        c.wr_wm = w[WR_LSB + FRAC_W +: ADDR_W];
        return c;
    endfunction

    function automatic logic [ADDR_W:0] depth_of(input logic [ADDR_W-1:0] size);
        return (size == '0) ? {1'b1, {ADDR_W{1'b0}}} : {1'b0, size};
    endfunction

endpackage

// File: rtl/wmfifo_regs.sv
module wmfifo_regs
    import wmfifo_pkg::*;
#(
    parameter int RECONF_CYCLES = RECONF_CYC
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr,
    input  logic             reg_sel,
    input  logic [CFG_W-1:0] reg_wdata,
    output logic [CFG_W-1:0] reg_rdata,
    output fifo_cfg_t        act_cfg,
    output logic             busy,
    output logic             apply_start,
    output logic [EN_W-1:0]  opt_en
);
    localparam int CNT_W = $clog2(RECONF_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RECONF_CYCLES - 1);

    logic [CFG_W-1:0] stage_q;
    fifo_cfg_t        act_q;
    logic             busy_q;
    logic [CNT_W-1:0] cnt_q;
    logic [EN_W-1:0]  en_q;
    logic             ctrl_wr;
    logic             cfg_wr;

    assign ctrl_wr     = reg_wr && (reg_sel_e'(reg_sel) == SEL_CTRL);
    assign cfg_wr      = reg_wr && (reg_sel_e'(reg_sel) == SEL_CFG);
    assign apply_start = ctrl_wr && reg_wdata[0] && !busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
            act_q   <= '0;
            busy_q  <= 1'b0;
            cnt_q   <= '0;
            en_q    <= '0;
        end else begin
            if (cfg_wr)
                stage_q <= reg_wdata & CFG_MASK;
            if (ctrl_wr)
                en_q <= reg_wdata[EN_W:1];
            if (apply_start) begin
                act_q  <= decode_cfg(stage_q);
                busy_q <= 1'b1;
                cnt_q  <= '0;
            end else if (busy_q) begin
                if (cnt_q == CNT_LAST)
                    busy_q <= 1'b0;
                else
                    cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    always_comb begin
        if (reg_sel_e'(reg_sel) == SEL_CTRL)
            reg_rdata = {{(CFG_W-EN_W-1){1'b0}}, en_q, busy_q};
        else
            reg_rdata = stage_q;
    end

    assign act_cfg = act_q;
    assign busy    = busy_q;
    assign opt_en  = en_q;

    // R1: active settings move only on an apply
    p_cfg_staged_r1: assert property (@(posedge clk) disable iff (rst)
        !apply_start |=> $stable(act_q));
    // R3: an apply starts a fresh busy window
    p_apply_busy_r3: assert property (@(posedge clk) disable iff (rst)
        apply_start |=> (busy_q && cnt_q == '0));
    // R3: the busy counter stays inside its window
    p_busy_bounded_r3: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> (cnt_q < CNT_W'(RECONF_CYCLES)));
    // R11: a second apply request does not restart the count
    p_no_restart_r11: assert property (@(posedge clk) disable iff (rst)
        (busy_q && ctrl_wr && reg_wdata[0] && cnt_q != CNT_LAST) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/wmfifo_mem.sv
module wmfifo_mem #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/wmfifo_ctrl.sv
module wmfifo_ctrl
    import wmfifo_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic              pop,
    input  logic              busy,
    input  logic              apply_start,
    input  fifo_cfg_t         cfg,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_ptr,
    output logic [ADDR_W-1:0] rd_ptr,
    output logic              full,
    output logic              empty,
    output logic              rd_wm_hit,
    output logic              wr_wm_hit,
    output logic              err
);
    logic [ADDR_W:0]   depth;
    logic [ADDR_W:0]   count_q;
    logic [ADDR_W-1:0] wp_q, rp_q;
    logic              err_q;
    logic              hold, do_push, do_pop;

    function automatic logic [ADDR_W-1:0] step_ptr(input logic [ADDR_W-1:0] p,
                                                    input logic [ADDR_W:0] d);
        return ({1'b0, p} == d - 1'b1) ? '0 : p + 1'b1;
    endfunction

    assign depth   = depth_of(cfg.size);
    assign full    = (count_q == depth);
    assign empty   = (count_q == '0);
    assign hold    = busy || apply_start;
    assign do_push = push && !hold && !full;
    assign do_pop  = pop && !hold && !empty;

    always_ff @(posedge clk) begin
        if (rst || hold) begin
            wp_q    <= '0;
            rp_q    <= '0;
            count_q <= '0;
            err_q   <= 1'b0;
        end else begin
            if (do_push)
                wp_q <= step_ptr(wp_q, depth);
            if (do_pop)
                rp_q <= step_ptr(rp_q, depth);
            if (do_push && !do_pop)
                count_q <= count_q + 1'b1;
            else if (do_pop && !do_push)
                count_q <= count_q - 1'b1;
            err_q <= (push && full) || (pop && empty);
        end
    end

    assign wr_en     = do_push;
    assign wr_ptr    = wp_q;
    assign rd_ptr    = rp_q;
    assign err       = err_q;
    assign rd_wm_hit = (count_q >= {1'b0, cfg.rd_wm});
    assign wr_wm_hit = ((depth - count_q) >= {1'b0, cfg.wr_wm});

    // R7: occupancy never exceeds the active depth
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
        count_q <= depth);
    // R4: the FIFO is empty after each busy cycle
    p_clear_on_busy_r4: assert property (@(posedge clk) disable iff (rst)
        busy |=> (count_q == '0 && !err_q));
    // R10: a refused push keeps the FIFO full and flags an error
    p_full_push_r10: assert property (@(posedge clk) disable iff (rst)
        (full && push && !pop && !hold) |=> (full && err_q && $stable(wp_q)));
    // R10: a refused pop keeps the FIFO empty and flags an error
    p_empty_pop_r10: assert property (@(posedge clk) disable iff (rst)
        (empty && pop && !push && !hold) |=> (empty && err_q && $stable(rp_q)));
endmodule

// File: rtl/wmfifo_top.sv
module wmfifo_top
    import wmfifo_pkg::*;
#(
    parameter int RECONF_CYCLES = RECONF_CYC
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_sel,
    input  logic [CFG_W-1:0]  reg_wdata,
    output logic [CFG_W-1:0]  reg_rdata,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] pop_data,
    output logic              full,
    output logic              empty,
    output logic              rd_wm_hit,
    output logic              wr_wm_hit,
    output logic              err,
    output logic              busy,
    output logic [EN_W-1:0]   opt_en
);
    fifo_cfg_t         act_cfg;
    logic              apply_start;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_ptr, rd_ptr;

    wmfifo_regs #(.RECONF_CYCLES(RECONF_CYCLES)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .reg_wr      (reg_wr),
        .reg_sel     (reg_sel),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .act_cfg     (act_cfg),
        .busy        (busy),
        .apply_start (apply_start),
        .opt_en      (opt_en)
    );

    wmfifo_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .push        (push),
        .pop         (pop),
        .busy        (busy),
        .apply_start (apply_start),
        .cfg         (act_cfg),
        .wr_en       (wr_en),
        .wr_ptr      (wr_ptr),
        .rd_ptr      (rd_ptr),
        .full        (full),
        .empty       (empty),
        .rd_wm_hit   (rd_wm_hit),
        .wr_wm_hit   (wr_wm_hit),
        .err         (err)
    );

    wmfifo_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
        .clk   (clk),
        .we    (wr_en),
        .waddr (wr_ptr),
        .wdata (push_data),
        .raddr (rd_ptr),
        .rdata (pop_data)
    );
endmodule

// File: tb/tb_wmfifo_top.sv
`timescale 1ns/1ps
module tb_wmfifo_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic        reg_sel = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        push = 1'b0;
    logic [31:0] push_data = '0;
    logic        pop = 1'b0;
    logic [31:0] pop_data;
    logic        full, empty, rd_wm_hit, wr_wm_hit, err, busy;
    logic [2:0]  opt_en;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    wmfifo_top dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .push(push),
        .push_data(push_data), .pop(pop), .pop_data(pop_data),
        .full(full), .empty(empty), .rd_wm_hit(rd_wm_hit),
        .wr_wm_hit(wr_wm_hit), .err(err), .busy(busy), .opt_en(opt_en)
    );

    always #2 clk = ~clk;

    // model state
    logic [31:0] m_q[$];
    logic [31:0] m_stage = '0;
    int          m_size = 0, m_rdwm = 0, m_wrwm = 0;
    bit          m_busy = 1'b0;
    int          m_bcnt = 0;
    logic [2:0]  m_en = '0;
    bit          m_err = 1'b0;

    function automatic int m_depth();
        return (m_size == 0) ? 256 : m_size;
    endfunction

    function automatic logic [31:0] cfg_word(int sz, int rw, int ww);
        return {2'b00, sz[7:0], 2'b00, rw[7:0], 2'b00, ww[7:0], 2'b00};
    endfunction

    function automatic logic [31:0] exp_rdata(bit sel);
        return sel ? {28'd0, m_en, m_busy} : m_stage;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_state();
        int occ = m_q.size();
        chk("R7/R2 full",   32'(full),  32'(occ == m_depth()));
        chk("R7/R4 empty",  32'(empty), 32'(occ == 0));
        chk("R8 rd_wm_hit", 32'(rd_wm_hit), 32'(occ >= m_rdwm));
        chk("R9 wr_wm_hit", 32'(wr_wm_hit), 32'((m_depth() - occ) >= m_wrwm));
        chk("R10 err",      32'(err),   32'(m_err));
        chk("R3/R11 busy",  32'(busy),  32'(m_busy));
        chk("R5 opt_en",    32'(opt_en), 32'(m_en));
        if (occ != 0 && !m_busy)
            chk("R6 pop_data", pop_data, m_q[0]);
    endtask

    task automatic cyc(bit pu, logic [31:0] d, bit po, bit rw, bit sel, logic [31:0] wd);
        bit st, f, e;
        @(negedge clk);
        check_state();
        push = pu; push_data = d; pop = po;
        reg_wr = rw; reg_sel = sel; reg_wdata = wd;
        #1;
        chk(sel ? "R3/R5 ctrl_rd" : "R1 cfg_rd", reg_rdata, exp_rdata(sel));
        @(posedge clk);
        st = rw && sel && wd[0] && !m_busy;
        f  = (m_q.size() == m_depth());
        e  = (m_q.size() == 0);
        if (!m_busy && !st) begin
            m_err = (pu && f) || (po && e);
            if (po && !e) void'(m_q.pop_front());
            if (pu && !f) m_q.push_back(d);
        end else begin
            m_err = 1'b0;
        end
        if (st) begin
            m_size = int'(m_stage[29:22]);
            m_rdwm = int'(m_stage[19:12]);
            m_wrwm = int'(m_stage[9:2]);
            m_q.delete();
            m_busy = 1'b1;
            m_bcnt = 0;
        end else if (m_busy) begin
            m_q.delete();
            if (m_bcnt == 3) m_busy = 1'b0;
            else m_bcnt++;
        end
        if (rw && !sel) m_stage = wd & 32'h3FFF_FFFF;
        if (rw && sel)  m_en = wd[3:1];
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc(0, '0, 0, 0, i[0], '0);
    endtask

    // R1 R2 R3 R4: stage, apply and try traffic while busy
    task automatic apply_cfg(int sz, int rw, int ww);
        cyc(0, '0, 0, 1, 0, cfg_word(sz, rw, ww));
        cyc(1, $urandom, 1, 1, 1, {28'd0, 3'($urandom), 1'b1});
        for (int i = 0; i < 5; i++) cyc(1, $urandom, 1, 0, 1, '0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // reset state: depth 256, thresholds 0
        idle(2);

        // R2: low field bits stored but ignored, reserved bits read zero (R1)
        cyc(0, '0, 0, 1, 0, 32'hFFFF_FFFF);
        idle(2);
        // R1: staged write leaves active settings alone
        for (int i = 0; i < 6; i++) cyc(1, $urandom, 0, 0, 0, '0);
        cyc(0, '0, 0, 1, 1, 32'h0000_0001);
        // R11: repeat apply requests during busy
        cyc(0, '0, 0, 1, 1, 32'h0000_000F);
        cyc(0, '0, 0, 1, 1, 32'h0000_0003);
        idle(4);

        // small depth: fill past full, drain past empty (R10)
        apply_cfg(4, 2, 3);
        for (int i = 0; i < 6; i++) cyc(1, 32'hA000_0000 + i, 0, 0, 0, '0);
        cyc(1, 32'hBEEF, 1, 0, 0, '0);   // R10: pop with push when full
        for (int i = 0; i < 6; i++) cyc(0, '0, 1, 0, 0, '0);
        cyc(1, 32'h1234, 1, 0, 0, '0);   // push while empty + pop
        idle(2);

        // R2: 64-entry encoding
        apply_cfg(64, 32, 16);
        for (int i = 0; i < 70; i++) cyc(1, $urandom, 0, 0, 0, '0);
        for (int i = 0; i < 70; i++) cyc(0, '0, 1, 0, 0, '0);

        // R2: size 0 means 256
        apply_cfg(0, 200, 100);
        for (int i = 0; i < 258; i++) cyc(1, $urandom, i[2] & i[0], 0, 0, '0);
        for (int i = 0; i < 260; i++) cyc(i[3], $urandom, 1, 0, 0, '0);

        // random phases
        for (int ph = 0; ph < 8; ph++) begin
            int sz;
            sz = (ph == 0) ? 1 : (ph == 1) ? 255 : int'($urandom_range(0, 40));
            apply_cfg(sz, int'($urandom_range(0, 45)), int'($urandom_range(0, 45)));
            for (int i = 0; i < 300; i++) begin
                int r;
                bit rw;
                r = int'($urandom_range(0, 99));
                rw = (r < 4);
                cyc(($urandom_range(0, 99) < 55), $urandom,
                    ($urandom_range(0, 99) < 45), rw, r[0],
                    r[0] ? {28'd0, 3'($urandom), 1'($urandom_range(0, 3) == 0)} : $urandom);
            end
            idle(5);
        end

        @(negedge clk);
        check_state();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

endmodule